// File: doc/BRIEF.md
# Partitioned Tag Tracker

This block watches the 9-bit transaction tags used by one to four request ports that share a single space of 512 tags. The space is cut into fixed, contiguous slices, one per port, and the slice boundaries depend only on the configured number of ports. Whenever a port presents a non-posted request, the tracker checks that the tag falls inside that port's own slice and that it is not already outstanding. If both checks pass, the tag is marked busy.

A returning response clears its tag, and the tag may then be issued again. Posted requests carry no meaningful tag. They never touch the busy state. A bad request is reported on a one-cycle error flag, together with the port and the tag, and it leaves the busy state untouched. A response whose tag was not outstanding raises a separate flag. A per-port count of outstanding tags is always visible. In any single cycle the block can handle one response and one request from each port. The release from the response is applied before any claim is checked.

Top module: `tag_tracker`

## Requirements
- R1: After reset every tag is free, every per-port count reads 0 and both error flags are low.
- R2: The slices are as follows. One port owns tags 0 to 511. Two ports own 0..255 and 256..511. Three ports own 0..175, 176..351 and 352..511. Four ports own 128 tags each, starting at 0, 128, 256 and 384. Bit p of `err_req_mask` refers to port p.
- R3: A non-posted request whose tag is in range and free marks the tag busy. The issuing port's count is one higher in the cycle after the request.
- R4: A posted request (`req_posted` bit = 1) is never checked or tracked, whatever its tag. It changes no count, raises no error, and does not make its tag busy.
- R5: A non-posted request whose tag is outside its port's slice sets that port's bit in `err_req_mask` in the next cycle, with `err_req_dup` = 0. It changes no busy state and no count.
- R6: A non-posted request whose tag is already busy sets that port's mask bit with `err_req_dup` = 1. Busy state and counts are unchanged.
- R7: A response to a busy tag frees it. The owning port's count drops by one in the next cycle, and a later request may claim the tag again.
- R8: A response whose tag is not busy raises `err_rsp_valid` with `err_rsp_tag` for one cycle, and no count changes.
- R9: When a response frees a tag in the same cycle that a request claims that tag, the release is applied first. The claim succeeds, no error is raised, and the count nets to unchanged.
- R10: Requests from several ports in one cycle are judged independently. When more than one port fails, `err_req_port`, `err_req_tag` and `err_req_dup` describe the lowest-numbered failing port.
- R11: Error outputs last one cycle. With no faulty input, the mask, the port, the tag, the dup bit and both response fields read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NUM_PORTS | Request accepted this cycle, one bit per port |
| req_posted | input | NUM_PORTS | Request is posted (untracked), one bit per port |
| req_tag | input | NUM_PORTS*TAG_W | Request tags, port p at bits [p*TAG_W +: TAG_W] |
| rsp_valid | input | 1 | A response returns this cycle |
| rsp_tag | input | TAG_W | Tag carried by the response |
| inflight_cnt | output | NUM_PORTS*CNT_W | Outstanding tags per port, port p at [p*CNT_W +: CNT_W] |
| err_req_mask | output | NUM_PORTS | Ports whose request failed in the previous cycle |
| err_req_port | output | PID_W | Lowest failing port |
| err_req_tag | output | TAG_W | Tag of that port's failing request |
| err_req_dup | output | 1 | 1 = tag was busy, 0 = tag outside the port's slice |
| err_rsp_valid | output | 1 | Response arrived for a tag that was not busy |
| err_rsp_tag | output | TAG_W | Tag of that unexpected response |

## Verification
The main function is driven with four kinds of pattern. Single legal claims on every port set the basic count. Tags placed exactly on slice edges, in both the four-port and the uneven three-port splits, separate an off-by-one boundary from a correct one. Mixed cycles, where several ports fail at once, expose a wrong priority in the reported port or a wrong choice between the busy and range causes. Response cycles that free, double-free, or free-and-reclaim the same tag tell release-before-claim ordering apart from the opposite ordering. They also show whether a posted request quietly left a tag behind.

// File: rtl/tagtrk_pkg.sv
package tagtrk_pkg;

  // Slice width: equal share rounded up to a multiple of 16 tags.
  function automatic int unsigned slice_size(int unsigned num_tags, int unsigned nports);
    return ((num_tags / nports + 15) / 16) * 16;
  endfunction

  function automatic int unsigned range_lo(int unsigned num_tags, int unsigned nports,
                                           int unsigned p);
    return p * slice_size(num_tags, nports);
  endfunction

  function automatic int unsigned range_hi(int unsigned num_tags, int unsigned nports,
                                           int unsigned p);
    if (p == nports - 1) return num_tags - 1;
    return range_lo(num_tags, nports, p + 1) - 1;
  endfunction

  function automatic int unsigned tag_owner(int unsigned num_tags, int unsigned nports,
                                            int unsigned tag);
    int unsigned o;
    o = 0;
    for (int unsigned p = 1; p < nports; p++)
      if (tag >= range_lo(num_tags, nports, p)) o = p;
    return o;
  endfunction

endpackage

// File: rtl/tagtrk_range_chk.sv
module tagtrk_range_chk #(
  parameter int unsigned TAG_W     = 9,
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PORT_ID   = 0
) (
  input  logic [TAG_W-1:0] tag,
  output logic             in_range
);
  import tagtrk_pkg::*;

  localparam int unsigned NUM_TAGS = 1 << TAG_W;
  localparam int unsigned LO = range_lo(NUM_TAGS, NUM_PORTS, PORT_ID);
  localparam int unsigned HI = range_hi(NUM_TAGS, NUM_PORTS, PORT_ID);

  logic lo_ok, hi_ok;

  generate
    if (LO == 0) begin : g_lo_open
      assign lo_ok = 1'b1;
    end else begin : g_lo_cmp
      assign lo_ok = (tag >= TAG_W'(LO));
    end
    if (HI == NUM_TAGS - 1) begin : g_hi_open
      assign hi_ok = 1'b1;
    end else begin : g_hi_cmp
      assign hi_ok = (tag <= TAG_W'(HI));
    end
  endgenerate

  assign in_range = lo_ok && hi_ok;
endmodule

// File: rtl/tagtrk_busy_table.sv
module tagtrk_busy_table #(
  parameter int unsigned TAG_W     = 9,
  parameter int unsigned NUM_PORTS = 4,
  localparam int unsigned NUM_TAGS = 1 << TAG_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rel_en,
  input  logic [TAG_W-1:0]           rel_tag,
  input  logic [NUM_PORTS-1:0]       set_en,
  input  logic [NUM_PORTS*TAG_W-1:0] set_tag,
  output logic [NUM_TAGS-1:0]        busy_q
);
  logic [NUM_TAGS-1:0] busy_nxt;

  always_comb begin
    busy_nxt = busy_q;
    if (rel_en) busy_nxt[rel_tag] = 1'b0;
    for (int p = 0; p < int'(NUM_PORTS); p++)
      if (set_en[p]) busy_nxt[set_tag[p*TAG_W +: TAG_W]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= busy_nxt;
  end
endmodule

// File: rtl/tagtrk_port_cnt.sv
module tagtrk_port_cnt #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else begin
      case ({inc, dec})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/tag_tracker.sv
module tag_tracker #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned TAG_W     = 9,
  localparam int unsigned NUM_TAGS = 1 << TAG_W,
  localparam int unsigned CNT_W    = $clog2(NUM_TAGS + 1),
  localparam int unsigned PID_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PORTS-1:0]       req_valid,
  input  logic [NUM_PORTS-1:0]       req_posted,
  input  logic [NUM_PORTS*TAG_W-1:0] req_tag,
  input  logic                       rsp_valid,
  input  logic [TAG_W-1:0]           rsp_tag,
  output logic [NUM_PORTS*CNT_W-1:0] inflight_cnt,
  output logic [NUM_PORTS-1:0]       err_req_mask,
  output logic [PID_W-1:0]           err_req_port,
  output logic [TAG_W-1:0]           err_req_tag,
  output logic                       err_req_dup,
  output logic                       err_rsp_valid,
  output logic [TAG_W-1:0]           err_rsp_tag
);
  import tagtrk_pkg::*;

  // Named internal events (observed by the bound checker)
  logic [NUM_TAGS-1:0]  busy_q;
  logic                 rsp_hit;
  logic                 rsp_miss;
  logic [PID_W-1:0]     rel_owner;
  logic [NUM_PORTS-1:0] tracked;
  logic [NUM_PORTS-1:0] in_range;
  logic [NUM_PORTS-1:0] busy_seen;
  logic [NUM_PORTS-1:0] claim;
  logic [NUM_PORTS-1:0] bad_range;
  logic [NUM_PORTS-1:0] bad_dup;
  logic [NUM_PORTS-1:0] dec;

  assign rsp_hit   = rsp_valid &&  busy_q[rsp_tag];
  assign rsp_miss  = rsp_valid && !busy_q[rsp_tag];
  assign rel_owner = PID_W'(tag_owner(NUM_TAGS, NUM_PORTS, int'(rsp_tag)));

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic [TAG_W-1:0] tag_p;
      assign tag_p = req_tag[p*TAG_W +: TAG_W];

      tagtrk_range_chk #(.TAG_W(TAG_W), .NUM_PORTS(NUM_PORTS), .PORT_ID(p)) u_rng (
        .tag      (tag_p),
        .in_range (in_range[p])
      );

      // Release from this cycle's response is seen before the claim.
      assign busy_seen[p] = busy_q[tag_p] && !(rsp_hit && (rsp_tag == tag_p));
      assign tracked[p]   = req_valid[p] && !req_posted[p];
      assign bad_range[p] = tracked[p] && !in_range[p];
      assign bad_dup[p]   = tracked[p] &&  in_range[p] &&  busy_seen[p];
      assign claim[p]     = tracked[p] &&  in_range[p] && !busy_seen[p];
      assign dec[p]       = rsp_hit && (rel_owner == PID_W'(p));

      tagtrk_port_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (claim[p]),
        .dec   (dec[p]),
        .cnt   (inflight_cnt[p*CNT_W +: CNT_W])
      );
    end
  endgenerate

  tagtrk_busy_table #(.TAG_W(TAG_W), .NUM_PORTS(NUM_PORTS)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .rel_en  (rsp_hit),
    .rel_tag (rsp_tag),
    .set_en  (claim),
    .set_tag (req_tag),
    .busy_q  (busy_q)
  );

  // Lowest failing port wins the reported fields.
  logic [NUM_PORTS-1:0] bad_any;
  logic [PID_W-1:0]     sel_port;
  logic [TAG_W-1:0]     sel_tag;
  logic                 sel_dup;

  assign bad_any = bad_range | bad_dup;

  always_comb begin
    sel_port = '0;
    sel_tag  = '0;
    sel_dup  = 1'b0;
    for (int p = int'(NUM_PORTS) - 1; p >= 0; p--) begin
      if (bad_any[p]) begin
        sel_port = PID_W'(p);
        sel_tag  = req_tag[p*TAG_W +: TAG_W];
        sel_dup  = bad_dup[p];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_req_mask  <= '0;
      err_req_port  <= '0;
      err_req_tag   <= '0;
      err_req_dup   <= 1'b0;
      err_rsp_valid <= 1'b0;
      err_rsp_tag   <= '0;
    end else begin
      err_req_mask  <= bad_any;
      err_req_port  <= sel_port;
      err_req_tag   <= sel_tag;
      err_req_dup   <= sel_dup;
      err_rsp_valid <= rsp_miss;
      err_rsp_tag   <= rsp_miss ? rsp_tag : '0;
    end
  end
endmodule

// File: rtl/tag_tracker_chk.sv
module tag_tracker_chk #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned TAG_W     = 9,
  localparam int unsigned NUM_TAGS = 1 << TAG_W,
  localparam int unsigned CNT_W    = $clog2(NUM_TAGS + 1)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_TAGS-1:0]        busy_q,
  input logic [NUM_PORTS*CNT_W-1:0] inflight_cnt,
  input logic [NUM_PORTS-1:0]       claim,
  input logic [NUM_PORTS-1:0]       in_range,
  input logic [NUM_PORTS-1:0]       req_valid,
  input logic [NUM_PORTS-1:0]       req_posted,
  input logic [NUM_PORTS*TAG_W-1:0] req_tag,
  input logic                       rsp_valid,
  input logic [TAG_W-1:0]           rsp_tag,
  input logic [NUM_PORTS-1:0]       err_req_mask,
  input logic                       err_rsp_valid
);
  int cnt_sum;
  always_comb begin
    cnt_sum = 0;
    for (int p = 0; p < int'(NUM_PORTS); p++)
      cnt_sum = cnt_sum + int'(inflight_cnt[p*CNT_W +: CNT_W]);
  end

  // R7: the per-port counters always add up to the number of busy tags
  p_count_matches_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_sum == $countones(busy_q));

  // R4: posted-only cycles with no response leave the busy table alone
  p_posted_no_effect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_valid && ((req_valid & ~req_posted) == '0)) |=> (busy_q == $past(busy_q)));

  // R8: a response to a free tag is flagged
  p_unexpected_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !busy_q[rsp_tag]) |=> err_rsp_valid);

  // R11: the response error is only ever a consequence of a response
  p_rsp_err_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_rsp_valid |-> $past(rsp_valid));

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
      // R5: out-of-slice tracked request is flagged on its own port bit
      p_range_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid[p] && !req_posted[p] && !in_range[p]) |=> err_req_mask[p]);

      // R3: a successful claim leaves the tag busy
      p_claim_marks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        claim[p] |=> busy_q[$past(req_tag[p*TAG_W +: TAG_W])]);

      // R6: a claim never coexists with an error for the same port
      p_claim_no_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        claim[p] |=> !err_req_mask[p]);
    end
  endgenerate
endmodule

bind tag_tracker tag_tracker_chk #(.NUM_PORTS(NUM_PORTS), .TAG_W(TAG_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy_q        (busy_q),
  .inflight_cnt  (inflight_cnt),
  .claim         (claim),
  .in_range      (in_range),
  .req_valid     (req_valid),
  .req_posted    (req_posted),
  .req_tag       (req_tag),
  .rsp_valid     (rsp_valid),
  .rsp_tag       (rsp_tag),
  .err_req_mask  (err_req_mask),
  .err_rsp_valid (err_rsp_valid)
);

// File: tb/test_tag_tracker.sv
`timescale 1ns/1ps
module test_tag_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  // Four-port instance
  logic [3:0]  req_valid = '0, req_posted = '0;
  logic [35:0] req_tag = '0;
  logic        rsp_valid = 1'b0;
  logic [8:0]  rsp_tag = '0;
  logic [39:0] inflight_cnt;
  logic [3:0]  err_req_mask;
  logic [1:0]  err_req_port;
  logic [8:0]  err_req_tag, err_rsp_tag;
  logic        err_req_dup, err_rsp_valid;

  tag_tracker i_tag_tracker (
    .clk, .rst_n, .req_valid, .req_posted, .req_tag, .rsp_valid, .rsp_tag,
    .inflight_cnt, .err_req_mask, .err_req_port, .err_req_tag, .err_req_dup,
    .err_rsp_valid, .err_rsp_tag);

  // Three-port instance for the uneven split
  logic [2:0]  v3 = '0, p3 = '0;
  logic [26:0] t3 = '0;
  logic [29:0] cnt3;
  logic [2:0]  mask3;
  logic [1:0]  port3;
  logic [8:0]  etag3, rtag3;
  logic        dup3, rerr3;

  tag_tracker #(.NUM_PORTS(3)) i_tag_tracker_3p (
    .clk, .rst_n, .req_valid(v3), .req_posted(p3), .req_tag(t3),
    .rsp_valid(1'b0), .rsp_tag(9'd0), .inflight_cnt(cnt3), .err_req_mask(mask3),
    .err_req_port(port3), .err_req_tag(etag3), .err_req_dup(dup3),
    .err_rsp_valid(rerr3), .err_rsp_tag(rtag3));

  typedef struct packed {
    logic [39:0] cnt;
    logic [3:0]  mask;
    logic [1:0]  port;
    logic [8:0]  tag;
    logic        dup;
    logic        rerr;
    logic [8:0]  rtag;
  } exp_t;

  exp_t  exp_q[$];
  string lbl_q[$];
  int    n_chk = 0, n_fail = 0;

  logic [511:0] mbusy = '0;
  int mcnt[4] = '{0, 0, 0, 0};

  // Driver: applies one cycle of stimulus and queues what must follow
  task automatic step(input string lbl, input logic [3:0] v, input logic [3:0] pst,
                      input int a, input int b, input int c, input int d,
                      input logic rv, input int rt);
    int t[4];
    logic [511:0] be, nb;
    exp_t e;
    bit first;
    logic hit;
    t = '{a, b, c, d};
    @(negedge clk);
    req_valid = v; req_posted = pst; rsp_valid = rv; rsp_tag = 9'(rt);
    req_tag = {9'(d), 9'(c), 9'(b), 9'(a)};
    e = '0;
    first = 1'b1;
    hit = rv && mbusy[rt];
    if (rv && !mbusy[rt]) begin e.rerr = 1'b1; e.rtag = 9'(rt); end
    be = mbusy;
    if (hit) be[rt] = 1'b0;
    nb = be;
    for (int p = 0; p < 4; p++) begin
      if (v[p] && !pst[p]) begin
        logic isbad, isdup;
        isbad = 1'b0; isdup = 1'b0;
        if (t[p] / 128 != p) isbad = 1'b1;
        else if (be[t[p]]) begin isbad = 1'b1; isdup = 1'b1; end
        else begin nb[t[p]] = 1'b1; mcnt[p]++; end
        if (isbad) begin
          e.mask[p] = 1'b1;
          if (first) begin e.port = 2'(p); e.tag = 9'(t[p]); e.dup = isdup; first = 1'b0; end
        end
      end
    end
    if (hit) mcnt[rt / 128]--;
    mbusy = nb;
    for (int p = 0; p < 4; p++) e.cnt[p*10 +: 10] = 10'(mcnt[p]);
    exp_q.push_back(e);
    lbl_q.push_back(lbl);
  endtask

  // Monitor: compares one queued item per cycle, after the edge settles
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e, act;
      string l;
      e = exp_q.pop_front();
      l = lbl_q.pop_front();
      act = {inflight_cnt, err_req_mask, err_req_port, err_req_tag, err_req_dup,
             err_rsp_valid, err_rsp_tag};
      n_chk++;
      if (act !== e) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", l, act, e);
      end
    end
  end

  task automatic chk3(input string lbl, input logic [2:0] v,
                      input int a, input int b, input int c, input logic [2:0] exp_mask);
    @(negedge clk);
    v3 = v; p3 = '0; t3 = {9'(c), 9'(b), 9'(a)};
    @(posedge clk); #1;
    n_chk++;
    if (mask3 !== exp_mask) begin
      n_fail++;
      $display("FAIL %s: actual mask %b expected %b", lbl, mask3, exp_mask);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    n_chk++;
    if ({inflight_cnt, err_req_mask, err_req_dup, err_rsp_valid} !== '0 ||
        {cnt3, mask3} !== '0) begin
      n_fail++;
      $display("FAIL R1: actual %h expected 0", {inflight_cnt, err_req_mask});
    end
    step("R3 claims on all ports", 4'b1111, 4'b0000, 5, 130, 300, 400, 1'b0, 0);
    step("R6 busy tag", 4'b0001, 4'b0000, 5, 0, 0, 0, 1'b0, 0);
    step("R5 out of slice", 4'b0010, 4'b0000, 0, 10, 0, 0, 1'b0, 0);
    step("R2 R10 edges and priority", 4'b1111, 4'b0000, 128, 127, 383, 384, 1'b0, 0);
    step("R4 posted", 4'b0011, 4'b0011, 500, 130, 0, 0, 1'b0, 0);
    step("R7 free", 4'b0000, 4'b0000, 0, 0, 0, 0, 1'b1, 130);
    step("R7 reuse", 4'b0010, 4'b0000, 0, 130, 0, 0, 1'b0, 0);
    step("R8 unexpected", 4'b0000, 4'b0000, 0, 0, 0, 0, 1'b1, 131);
    step("R9 release then claim", 4'b0001, 4'b0000, 5, 0, 0, 0, 1'b1, 5);
    step("R11 idle", 4'b0000, 4'b0000, 0, 0, 0, 0, 1'b0, 0);
    step("R4 posted tag untracked", 4'b0000, 4'b0000, 0, 0, 0, 0, 1'b1, 500);
    step("R10 dup and range mix", 4'b1100, 4'b0000, 0, 0, 300, 10, 1'b0, 0);
    step("R6 R7 dup after release", 4'b0100, 4'b0000, 0, 0, 300, 0, 1'b1, 300);
    step("R11 idle end", 4'b0000, 4'b0000, 0, 0, 0, 0, 1'b0, 0);
    repeat (3) @(posedge clk);
    chk3("R2 three-port legal edges", 3'b111, 175, 176, 352, 3'b000);
    chk3("R2 three-port crossed edges", 3'b111, 176, 175, 351, 3'b111);
    chk3("R2 three-port upper edges", 3'b110, 0, 351, 511, 3'b000);
    @(negedge clk);
    v3 = '0;
    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule